// File: doc/BRIEF.md
# Memory-Mapped Flash Window Guard

This block sits on the read path in front of an external flash controller and screens every read that targets the fixed 256 MiB address window reserved for memory-mapped flash (base 0x9000_0000 up to 0x9FFF_FFFF). A read that lands in the window reaches the controller only when the controller is in memory-mapped mode and the address lies inside the populated part of the flash. Reads that would touch unmapped bytes, or that arrive while the controller runs command-driven transfers, are stopped. Without the guard, speculative or stray loads could corrupt controller state or run past the end of the device.

Each request is decided in one cycle and the verdict appears on registered outputs the cycle after. Accepted and out-of-window reads are forwarded with their address. Denied reads complete at once with an error pulse, are never forwarded, and set a sticky fault flag that keeps the first denied address until software clears it. The populated size is a live input given as log2 of the byte count. A typical board drives 21 (2 MiB). Any value of 28 or more opens the whole window. The permitted span is built from a ladder of power-of-two limits, one per offset bit: each bit at or above the size exponent must be zero.

Top module: `flash_window_guard`

## Requirements
- R1: After synchronous reset, `grant_valid`, `deny_pulse` and `fault_sticky` are 0 and `fault_addr` is 0.
- R2: A valid request whose address lies outside 0x9000_0000..0x9FFF_FFFF is forwarded one cycle later (`grant_valid`=1, `grant_addr` equal to the request address), whatever the mode, with no error and no change to the fault state.
- R3: A valid in-window request with `mapped_mode`=0 is denied: one cycle later `deny_pulse`=1 and `grant_valid`=0.
- R4: With `mapped_mode`=1, an in-window request whose offset from 0x9000_0000 is below 2^`size_exp` is forwarded one cycle later.
- R5: With `mapped_mode`=1, an in-window request whose offset is 2^`size_exp` or more is denied one cycle later; for `size_exp`=21 the last forwarded address is 0x901F_FFFF and 0x9020_0000 is denied.
- R6: A `size_exp` of 28 or more permits the whole window in mapped mode; `size_exp`=0 permits only offset 0.
- R7: A denial sets `fault_sticky` in the same cycle as `deny_pulse` and loads `fault_addr` with the denied address; while the flag stays set, later denials do not change `fault_addr`.
- R8: `fault_clr` clears the flag and address on the next edge; if a denial is decided in the same cycle as the clear, the denial wins and its address is captured.
- R9: Mode and size are sampled together with each request; a change applies from the next request on and does not withdraw a grant already issued.
- R10: `grant_valid` and `deny_pulse` are never 1 in the same cycle, and a cycle without a valid request produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 32 | Read request address |
| mapped_mode | input | 1 | Flash controller is in memory-mapped mode |
| size_exp | input | 5 | log2 of the populated flash size in bytes |
| fault_clr | input | 1 | Clears the sticky fault record |
| grant_valid | output | 1 | Request forwarded to the controller (registered) |
| grant_addr | output | 32 | Forwarded address, meaningful while `grant_valid` is 1 |
| deny_pulse | output | 1 | Error response for a rejected request (one cycle) |
| fault_sticky | output | 1 | A request has been denied since the last clear |
| fault_addr | output | 32 | Address of the first denied request since the last clear |

## Verification
The fault record has two sources that can meet in one cycle: a software clear and a fresh denial. The bench raises `fault_clr` on the same cycle as a denied in-window read, and separately on a cycle with a grant, and expects the denial to win with its own address in the first case and a clean record in the second. A second overlap is a mode flip on the cycle right after a grant: the grant must still show while the following request is denied, and the reference model judges both on every clock.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_PASS  = 2'd1,
    VERD_GRANT = 2'd2,
    VERD_DENY  = 2'd3
  } verdict_t;
endpackage

// File: rtl/window_check.sv
module window_check #(
  parameter int                 ADDR_W   = 32,
  parameter int                 WIN_LOG2 = 28,
  parameter logic [ADDR_W-1:0]  WIN_BASE = 32'h9000_0000,
  parameter int                 SZ_W     = 5
) (
  input  logic                       valid_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       mapped_i,
  input  logic [SZ_W-1:0]            size_exp_i,
  output flash_guard_pkg::verdict_t  verdict_o
);
  import flash_guard_pkg::*;

  localparam int TAG_W = ADDR_W - WIN_LOG2;

  logic                in_window;
  logic [WIN_LOG2-1:0] offset;
  logic [WIN_LOG2-1:0] limit_mask;
  logic                over_limit;

  assign in_window = (addr_i[ADDR_W-1 -: TAG_W] == WIN_BASE[ADDR_W-1 -: TAG_W]);
  assign offset    = addr_i[WIN_LOG2-1:0];

  // One power-of-two limit per offset bit: a bit at or above the size
  // exponent lies outside the populated span.
  generate
    for (genvar b = 0; b < WIN_LOG2; b++) begin : g_limit
      assign limit_mask[b] = (b >= int'(size_exp_i));
    end
  endgenerate

  assign over_limit = |(offset & limit_mask);

  always_comb begin
    if (!valid_i)                   verdict_o = VERD_NONE;
    else if (!in_window)            verdict_o = VERD_PASS;
    else if (mapped_i && !over_limit) verdict_o = VERD_GRANT;
    else                            verdict_o = VERD_DENY;
  end
endmodule

// File: rtl/fault_latch.sv
module fault_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      addr_o <= '0;
    end else if (set_i && (clr_i || !flag_o)) begin
      flag_o <= 1'b1;
      addr_o <= addr_i;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      addr_o <= '0;
    end
  end

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> (flag_o && $stable(addr_o)));

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> (!flag_o && addr_o == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i) |=> (flag_o && addr_o == $past(addr_i)));
endmodule

// File: rtl/flash_window_guard.sv
module flash_window_guard #(
  parameter int                 ADDR_W   = 32,
  parameter int                 WIN_LOG2 = 28,
  parameter logic [ADDR_W-1:0]  WIN_BASE = 32'h9000_0000,
  parameter int                 SZ_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              mapped_mode,
  input  logic [SZ_W-1:0]   size_exp,
  input  logic              fault_clr,
  output logic              grant_valid,
  output logic [ADDR_W-1:0] grant_addr,
  output logic              deny_pulse,
  output logic              fault_sticky,
  output logic [ADDR_W-1:0] fault_addr
);
  import flash_guard_pkg::*;

  localparam int TAG_W = ADDR_W - WIN_LOG2;

  verdict_t verdict;
  logic     forward;
  logic     reject;

  window_check #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE), .SZ_W(SZ_W)
  ) u_check (
    .valid_i   (req_valid),
    .addr_i    (req_addr),
    .mapped_i  (mapped_mode),
    .size_exp_i(size_exp),
    .verdict_o (verdict)
  );

  assign forward = (verdict == VERD_PASS) || (verdict == VERD_GRANT);
  assign reject  = (verdict == VERD_DENY);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_addr  <= '0;
      deny_pulse  <= 1'b0;
    end else begin
      grant_valid <= forward;
      deny_pulse  <= reject;
      if (forward) grant_addr <= req_addr;
    end
  end

  fault_latch #(.ADDR_W(ADDR_W)) u_fault (
    .clk   (clk),
    .rst   (rst),
    .set_i (reject),
    .addr_i(req_addr),
    .clr_i (fault_clr),
    .flag_o(fault_sticky),
    .addr_o(fault_addr)
  );

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && deny_pulse));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!grant_valid && !deny_pulse));

  // R2
  outside_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[ADDR_W-1 -: TAG_W] != WIN_BASE[ADDR_W-1 -: TAG_W])
      |=> (grant_valid && grant_addr == $past(req_addr)));

  // R3
  unmapped_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mapped_mode && req_addr[ADDR_W-1 -: TAG_W] == WIN_BASE[ADDR_W-1 -: TAG_W])
      |=> (deny_pulse && !grant_valid));

  // R7
  deny_flags_chk: assert property (@(posedge clk) disable iff (rst)
    deny_pulse |-> fault_sticky);
endmodule

// File: tb/tb_flash_window_guard.sv
module tb_flash_window_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        mapped_mode;
  logic [4:0]  size_exp;
  logic        fault_clr;
  logic        grant_valid;
  logic [31:0] grant_addr;
  logic        deny_pulse;
  logic        fault_sticky;
  logic [31:0] fault_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  bit          e_grant, e_deny, e_flag;
  logic [31:0] e_gaddr, e_faddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_window_guard dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .mapped_mode(mapped_mode), .size_exp(size_exp), .fault_clr(fault_clr),
    .grant_valid(grant_valid), .grant_addr(grant_addr), .deny_pulse(deny_pulse),
    .fault_sticky(fault_sticky), .fault_addr(fault_addr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "grant_valid", {31'd0, grant_valid}, {31'd0, e_grant});
    chk(tag, "deny_pulse", {31'd0, deny_pulse}, {31'd0, e_deny});
    chk({tag, " R10"}, "both_outcomes", {31'd0, grant_valid & deny_pulse}, 32'd0);
    chk(tag, "fault_sticky", {31'd0, fault_sticky}, {31'd0, e_flag});
    chk(tag, "fault_addr", fault_addr, e_faddr);
    if (e_grant) chk(tag, "grant_addr", grant_addr, e_gaddr);
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input bit v, input logic [31:0] a, input bit m,
                     input int sz, input bit clr, input string tag);
    longint off;
    bit in_win, ok;
    req_valid = v; req_addr = a; mapped_mode = m; size_exp = 5'(sz); fault_clr = clr;
    in_win = (a >= 32'h9000_0000) && (a <= 32'h9FFF_FFFF);
    off    = longint'(a) - longint'(32'h9000_0000);
    ok     = !in_win || (m && (sz >= 28 || off < (longint'(1) << sz)));
    @(posedge clk);
    e_grant = v && ok;
    e_deny  = v && !ok;
    if (e_grant) e_gaddr = a;
    if (e_deny && (clr || !e_flag)) begin
      e_flag = 1; e_faddr = a;
    end else if (clr) begin
      e_flag = 0; e_faddr = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst = 1; req_valid = 0; req_addr = 0; mapped_mode = 0; size_exp = 5'd21; fault_clr = 0;
    repeat (2) @(negedge clk);
    e_grant = 0; e_deny = 0; e_flag = 0; e_gaddr = 0; e_faddr = 0;
    compare("R1 reset");
    rst = 0;

    cyc(0, 32'h0, 0, 21, 0, "R10 idle");
    cyc(1, 32'h2000_1000, 0, 21, 0, "R2 outside low");
    cyc(1, 32'h8FFF_FFFF, 0, 21, 0, "R2 below window");
    cyc(1, 32'hA000_0000, 1, 21, 0, "R2 above window");

    cyc(1, 32'h9000_0000, 0, 21, 0, "R3 unmapped base");
    cyc(1, 32'h9000_0010, 0, 21, 0, "R7 second deny keeps addr");
    cyc(1, 32'h3000_0000, 0, 21, 0, "R2 pass leaves fault");
    cyc(0, 32'h0, 0, 21, 1, "R8 clear");

    cyc(1, 32'h9000_0000, 1, 21, 0, "R4 mapped base");
    cyc(1, 32'h901F_FFFF, 1, 21, 0, "R5 last byte");
    cyc(1, 32'h9020_0000, 1, 21, 0, "R5 first beyond");
    cyc(1, 32'h9FFF_FFFF, 1, 21, 0, "R5 window top");
    cyc(1, 32'h9800_0000, 1, 21, 1, "R8 clear with deny");
    cyc(1, 32'h9000_0004, 1, 21, 1, "R8 clear with grant");

    cyc(1, 32'h9FFF_FFFF, 1, 28, 0, "R6 size 28");
    cyc(1, 32'h9ABC_DEF0, 1, 31, 0, "R6 size 31");
    cyc(1, 32'h9000_0000, 1, 0, 0, "R6 size 0 base");
    cyc(1, 32'h9000_0001, 1, 0, 1, "R6 size 0 next");
    cyc(0, 32'h0, 0, 21, 1, "R8 clear again");

    cyc(1, 32'h9000_0100, 1, 21, 0, "R9 grant before flip");
    cyc(1, 32'h9000_0100, 0, 21, 0, "R9 flipped to unmapped");
    cyc(0, 32'h9000_0100, 1, 21, 0, "R9 flip without request");
    cyc(1, 32'h9000_0200, 1, 21, 1, "R9 mapped again");
    cyc(1, 32'h9040_0000, 1, 23, 0, "R9 size grows");
    cyc(1, 32'h9040_0000, 1, 22, 0, "R9 size shrinks");

    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = (lfsr[3:2] == 2'b00) ? lfsr : {4'h9, 4'h0, lfsr[27:24] & 4'h1, lfsr[23:4]};
      cyc(lfsr[5] | lfsr[6], a, lfsr[7], 20 + int'(lfsr[10:8]), lfsr[11] & lfsr[12],
          "R4 R5 R7 R8 mixed");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule